// File: doc/BRIEF.md
# Quadrature Reference Square-Wave Generator

This block turns a single-bit reference square wave into two square waves at the same frequency: an in-phase wave that rises with each reference rising edge, and a quadrature wave that lags it by a quarter period. The reference may have any duty cycle. The two waves are meant to drive the switching inputs of a pair of synchronous demodulators. Only the rising edges of the reference matter.

The reference is first synchronised to the system clock. A period counter counts ticks between rising edges. At each edge, a quarter of the count (the count shifted right by two) is stored. An interval counter, restarted at each edge, fires every quarter-count ticks. These firings, merged with the edge itself, toggle a half-rate flip-flop. The in-phase output follows that flip-flop's rising steps and the quadrature output follows its falling steps. A prescaler can be selected so that long periods still fit in the counter. The outputs stay frozen until a usable period has been measured.

Top module: `quad_ref_gen`

## Requirements
- R1: After reset, `ref_i`, `ref_q`, `locked` and `overflow` are all 0.
- R2: With Q = floor(N/4), where N is the number of ticks between two reference rising edges, `ref_i` rises at the start of each period. `ref_i` falls 2Q ticks later and rises again 4Q ticks after the start, or at the next period start if that comes first. `ref_q` is high from Q ticks after the start until 3Q ticks after the start. For N a multiple of 4, this gives two 50% waves 90 degrees apart.
- R3: The outputs depend only on the spacing of rising edges and not on the reference duty cycle.
- R4: The quarter count used for a period is the tick count of the previous period shifted right by two bits.
- R5: With `presc_sel` = s, the counters advance once every 2^s clocks. The prescaler restarts at each rising edge, so N is 1 + floor((P-1)/2^s) for a period of P clocks.
- R6: `locked` rises at the first rising edge that ends a valid measurement. Until then, and whenever `locked` is 0, `ref_i` and `ref_q` hold their state.
- R7: A period with N below 4 (quarter count 0) is invalid: `locked` stays or goes 0.
- R8: If 2^CNT_W - 1 ticks pass without a rising edge, the period counter saturates and `overflow` becomes 1. The next rising edge clears `overflow` and ends an invalid period (`locked` = 0). The period after that locks again.
- R9: Each synchronised rising edge of `ref_in` gives exactly one single-clock edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | PSEL_W | Prescaler select: tick every 2^presc_sel clocks |
| ref_in | input | 1 | Asynchronous reference square wave |
| ref_i | output | 1 | In-phase (0 degree) output |
| ref_q | output | 1 | Quadrature (90 degree) output |
| locked | output | 1 | A valid period is in use |
| overflow | output | 1 | Period counter saturated since the last edge |

## Verification
The assertions assume the following about the inputs:
- `presc_sel` stays constant while the reference runs.
- The reference holds each level for at least one clock, so the synchroniser sees every rising edge.
- Rising edges are spaced far enough apart that the edge detector never has to merge two of them.

The stimulus respects all three. The reference is generated at the falling clock edge from integer high and low counts of at least one clock. `presc_sel` is only changed while reset is held. Each pattern runs for several periods before anything is measured, so the quarter count in use comes from the same pattern.

// File: rtl/qrg_pkg.sv
package qrg_pkg;
    localparam int QRG_CNT_W_DEF  = 15;
    localparam int QRG_PSEL_W_DEF = 3;

    typedef struct packed {
        logic half;
        logic wav_i;
        logic wav_q;
    } qrg_wave_t;
endpackage

// File: rtl/qrg_sync_edge.sv
module qrg_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ref_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;

    // R9: an edge event never lasts two clocks
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/qrg_prescaler.sv
module qrg_prescaler #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] sel,
    input  logic              rise,
    output logic              tick
);
    localparam int PC_W = (1 << PSEL_W);

    logic [PC_W-1:0] pc_d, pc_q;
    logic [PC_W-1:0] lim;

    always_comb begin
        lim  = (PC_W'(1) << sel) - PC_W'(1);
        tick = (pc_q == lim);
        pc_d = pc_q;
        if (rise || tick) pc_d = '0;
        else              pc_d = pc_q + PC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // R5: the prescaler restarts on every edge event
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (pc_q == '0));
endmodule

// File: rtl/qrg_period_meas.sv
module qrg_period_meas #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             tick,
    output logic [CNT_W-3:0] quarter,
    output logic             cap_ok,
    output logic             valid,
    output logic             sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             armed;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-3:0] quarter;
    } meas_t;

    meas_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        sat    = st_q.armed && (st_q.cnt == CNT_MAX);
        cap_ok = rise && st_q.armed && !sat && (st_q.cnt[CNT_W-1:2] != '0);
        if (rise) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CNT_W'(1);
            if (st_q.armed) begin
                st_d.quarter = st_q.cnt[CNT_W-1:2];
                st_d.valid   = cap_ok;
            end
        end else if (tick && st_q.armed && !sat) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quarter = st_q.quarter;
    assign valid   = st_q.valid;

    // R4: the period counter reloads to one after an edge
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (st_q.cnt == CNT_W'(1)));
    // R4: the quarter count only moves at an edge
    a_r4_quarter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(quarter));
    // R8: saturation persists until an edge
    a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !rise) |=> sat);
    // R7: a locked state always carries a nonzero quarter
    a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (quarter != '0));
endmodule

// File: rtl/qrg_phase_gen.sv
module qrg_phase_gen
    import qrg_pkg::*;
#(
    parameter int QW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          tick,
    input  logic          cap_ok,
    input  logic          valid,
    input  logic [QW-1:0] quarter,
    output logic          wav_i,
    output logic          wav_q
);
    typedef struct packed {
        logic [QW-1:0] ic;
        qrg_wave_t     w;
    } ph_t;

    ph_t  st_d, st_q;
    logic hit;

    always_comb begin
        st_d = st_q;
        hit  = valid && tick && (st_q.ic == quarter);
        if (rise) begin
            st_d.ic     = QW'(1);
            st_d.w.half = 1'b1;
            if (cap_ok) begin
                st_d.w.wav_i = 1'b1;
                st_d.w.wav_q = 1'b0;
            end
        end else if (valid && tick) begin
            if (hit) begin
                st_d.ic     = QW'(1);
                st_d.w.half = ~st_q.w.half;
                if (!st_q.w.half) st_d.w.wav_i = ~st_q.w.wav_i;
                else              st_d.w.wav_q = ~st_q.w.wav_q;
            end else begin
                st_d.ic = st_q.ic + QW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wav_i = st_q.w.wav_i;
    assign wav_q = st_q.w.wav_q;

    // R2: a valid edge resynchronises the outputs
    a_r2_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && cap_ok) |=> (wav_i && !wav_q));
    // R2: interval counter never passes the quarter while locked
    a_r2_ic_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !rise) |=> (st_q.ic <= quarter) || !valid);
    // R6: outputs frozen while unlocked and no valid edge
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !(rise && cap_ok)) |=> ($stable(wav_i) && $stable(wav_q)));
endmodule

// File: rtl/quad_ref_gen.sv
module quad_ref_gen
    import qrg_pkg::*;
#(
    parameter int CNT_W  = QRG_CNT_W_DEF,
    parameter int PSEL_W = QRG_PSEL_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic              ref_in,
    output logic              ref_i,
    output logic              ref_q,
    output logic              locked,
    output logic              overflow
);
    localparam int QW = CNT_W - 2;

    logic          rise;
    logic          tick;
    logic          cap_ok;
    logic          valid;
    logic [QW-1:0] quarter;

    qrg_sync_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .rise   (rise)
    );

    qrg_prescaler #(.PSEL_W(PSEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (presc_sel),
        .rise  (rise),
        .tick  (tick)
    );

    qrg_period_meas #(.CNT_W(CNT_W)) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .tick    (tick),
        .quarter (quarter),
        .cap_ok  (cap_ok),
        .valid   (valid),
        .sat     (overflow)
    );

    qrg_phase_gen #(.QW(QW)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .tick    (tick),
        .cap_ok  (cap_ok),
        .valid   (valid),
        .quarter (quarter),
        .wav_i   (ref_i),
        .wav_q   (ref_q)
    );

    assign locked = valid;

    // R8: overflow clears one clock after an edge
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !overflow);
endmodule

// File: tb/quad_ref_gen_bench.sv
module quad_ref_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] presc_sel = 3'd0;
    logic       ref_in;
    logic       ref_i, ref_q, locked, overflow;

    int checks = 0;
    int errors = 0;
    int gen_hi = 8;
    int gen_lo = 8;
    bit gen_en = 1'b0;

    always #4 clk = ~clk;

    quad_ref_gen u_quad_ref_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_sel (presc_sel),
        .ref_in    (ref_in),
        .ref_i     (ref_i),
        .ref_q     (ref_q),
        .locked    (locked),
        .overflow  (overflow)
    );

    initial begin
        int ph = 0;
        ref_in = 1'b0;
        forever begin
            @(negedge clk);
            if (gen_en) begin
                ref_in = (ph < gen_hi);
                ph = (ph + 1 >= gen_hi + gen_lo) ? 0 : ph + 1;
            end else begin
                ref_in = 1'b0;
                ph = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] sel);
        gen_en = 1'b0;
        rst_n = 1'b0;
        presc_sel = sel;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_pattern(input int hi, input int lo, input int periods);
        gen_hi = hi;
        gen_lo = lo;
        gen_en = 1'b1;
        repeat (periods * (hi + lo)) @(negedge clk);
    endtask

    // per: i rise to rise, hi: i high time, qd: q rise after i rise, qh: q high time
    task automatic measure(output int per, output int hi, output int qd, output int qh);
        logic pi, pq;
        int   c, qr;
        per = -1; hi = -1; qd = -1; qh = -1; qr = -1;
        pi = ref_i;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (ref_i && !pi) break;
            pi = ref_i;
        end
        c = 0; pi = ref_i; pq = ref_q;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            c++;
            if (ref_q && !pq && qr < 0) begin qr = c; qd = c; end
            if (!ref_q && pq && qr >= 0 && qh < 0) qh = c - qr;
            if (!ref_i && pi && hi < 0) hi = c;
            if (ref_i && !pi) begin per = c; break; end
            pi = ref_i; pq = ref_q;
        end
    endtask

    task automatic t_reset;
        do_reset(3'd0);
        check("R1 ref_i", ref_i, 0);
        check("R1 ref_q", ref_q, 0);
        check("R1 locked", locked, 0);
        check("R1 overflow", overflow, 0);
    endtask

    task automatic t_even;
        int per, hi, qd, qh;
        do_reset(3'd0);
        run_pattern(8, 8, 5);
        check("R6 locked", locked, 1);
        measure(per, hi, qd, qh);
        check("R2 period16", per, 16);
        check("R2 ihigh16", hi, 8);
        check("R4 qdelay16", qd, 4);
        check("R2 qhigh16", qh, 8);
    endtask

    task automatic t_duty;
        int per, hi, qd, qh;
        do_reset(3'd0);
        run_pattern(5, 15, 5);
        measure(per, hi, qd, qh);
        check("R3 period20", per, 20);
        check("R3 ihigh20", hi, 10);
        check("R3 qdelay20", qd, 5);
    endtask

    task automatic t_odd;
        int per, hi, qd, qh;
        do_reset(3'd0);
        run_pattern(9, 9, 5);
        measure(per, hi, qd, qh);
        check("R2 period18", per, 18);
        check("R2 ihigh18", hi, 10);
        check("R2 qhigh18", qh, 8);
    endtask

    task automatic t_presc;
        int per, hi, qd, qh;
        do_reset(3'd2);
        run_pattern(32, 32, 5);
        measure(per, hi, qd, qh);
        check("R5 period64", per, 64);
        check("R5 ihigh64", hi, 32);
        check("R5 qdelay64", qd, 16);
    endtask

    task automatic t_short;
        do_reset(3'd0);
        run_pattern(1, 1, 20);
        check("R7 locked", locked, 0);
        check("R7 ref_i held", ref_i, 0);
        check("R7 ref_q held", ref_q, 0);
    endtask

    task automatic t_overflow;
        int per, hi, qd, qh;
        do_reset(3'd0);
        run_pattern(8, 8, 4);
        gen_en = 1'b0;
        repeat (33000) @(negedge clk);
        check("R8 overflow set", overflow, 1);
        gen_hi = 8; gen_lo = 8; gen_en = 1'b1;
        repeat (8) @(negedge clk);
        check("R8 overflow clear", overflow, 0);
        check("R8 unlocked", locked, 0);
        repeat (80) @(negedge clk);
        check("R8 relocked", locked, 1);
        measure(per, hi, qd, qh);
        check("R8 period after", per, 16);
    endtask

    initial begin
        #1200000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_even();
        t_duty();
        t_odd();
        t_presc();
        t_short();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule